// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Status Controller

This block gathers interrupt events for a bus-master peripheral that has two event groups: a bus-side group and a DMA-side group. Each group keeps a host-visible status register, a hidden second-level register and an enable register. It also drives a summary pending bit that a host can poll. One active-low request pin serves both groups.

While a group's summary bit is clear, events land directly in its visible status register. While the summary bit is set, later events are held in the hidden register, and repeated events there merge by OR. When the host reads a group's status, that group's first level is cleared and the hidden contents move up into the visible register. After any read that clears a pending entry, the request pin is held inactive for a fixed number of cycles. The pin then comes back if a promoted entry still asks for it.

An event bit with its enable bit clear is still recorded in the visible register. If that bit is nonfatal, it sets neither the summary bit nor the pin. If the bit is fatal (selected per bit by a parameter), it always sets the summary bit, so a host that polls can see it. Only its effect on the pin is suppressed.

Top module: `intr_stack_ctrl`

## Requirements
- R1: With the group's summary bit clear, an event bit sets the same bit of the visible status. If that bit is enabled (enable register bit = 1), the summary bit is set and the request pin goes low (active).
- R2: While the group's summary bit is set and no status read is in progress, new events leave the visible status unchanged.
- R3: Events that arrive while the summary bit is set accumulate by OR in the hidden register, so several separate events all appear after promotion.
- R4: A status read replaces the visible status with the hidden contents (OR any event of that same cycle) and empties the hidden register. The summary bit is then set only if a promoted bit is enabled or fatal.
- R5: After a read of a group whose summary bit was set, irq_no stays high for exactly GAP_CYC cycles. After that it goes low again if any group still holds an entry that drives the pin.
- R6: An event on a disabled nonfatal bit sets its visible status bit but leaves the summary bit clear and irq_no high.
- R7: After such a masked nonfatal post, later events still go straight into the visible register, and the earlier bit stays set beside them.
- R8: Writing the enable register while irq_no is low does not make irq_no go high, and does not clear the summary bit.
- R9: Events arriving in the same cycle, in one group or in both groups, all appear together in the first-level status of their groups.
- R10: An event on a fatal bit (BUS_FATAL / DMA_FATAL bit = 1) always sets the summary bit. If that bit is disabled, irq_no stays high.
- R11: After reset, all status, hidden and enable registers are zero, both summary bits are 0 and irq_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_evt_i | input | W | Bus-side event pulses, one cycle each |
| dma_evt_i | input | W | DMA-side event pulses, one cycle each |
| bus_en_wr_i | input | 1 | Write strobe for the bus-side enable register |
| dma_en_wr_i | input | 1 | Write strobe for the DMA-side enable register |
| en_wdata_i | input | W | Write data for the enable registers (1 = enabled) |
| bus_rd_i | input | 1 | Host read strobe of bus-side status (clear and promote) |
| dma_rd_i | input | 1 | Host read strobe of DMA-side status (clear and promote) |
| bus_stat_o | output | W | Bus-side visible status |
| dma_stat_o | output | W | DMA-side visible status |
| bus_pend_o | output | 1 | Bus-side summary pending bit |
| dma_pend_o | output | 1 | DMA-side summary pending bit |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
A corrupted hidden register stays invisible until the next status read. After that read it shows up in the visible status the following cycle, as missing or extra bits. A summary bit or request flag that latches wrongly shows on bus_pend_o, dma_pend_o or irq_no one cycle after the event that caused it. A gap counter that loads the wrong value only shows when irq_no falls back low, GAP_CYC cycles after the read. For that reason the bench samples irq_no on both sides of that edge.

// File: rtl/intr_stack_pkg.sv
`timescale 1ns/1ps
package intr_stack_pkg;
  localparam int unsigned NUM_GRP = 2;
  localparam int unsigned DEF_W   = 8;
  typedef enum int unsigned {GRP_BUS = 0, GRP_DMA = 1} grp_e;
endpackage

// File: rtl/intr_en_reg.sv
`timescale 1ns/1ps
module intr_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_gap_tmr.sv
`timescale 1ns/1ps
module irq_gap_tmr #(
  parameter int unsigned GAP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(GAP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r5_gap_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> busy_o);
  a_r5_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i && busy_o |=> cnt_q < $past(cnt_q));
endmodule

// File: rtl/intr_grp.sv
`timescale 1ns/1ps
module intr_grp #(
  parameter int unsigned    W     = 8,
  parameter logic [W-1:0]   FATAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic         rd_i,
  output logic [W-1:0] stat_o,
  output logic         pend_o,
  output logic         req_o,
  output logic         clr_o
);
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] hid_q, hid_d;
  logic         pend_q, pend_d;
  logic         req_q, req_d;
  logic [W-1:0] promo;
  logic [W-1:0] qual_en;

  assign qual_en = en_i | FATAL;
  assign promo   = hid_q | evt_i;

  always_comb begin
    stat_d = stat_q;
    hid_d  = hid_q;
    pend_d = pend_q;
    req_d  = req_q;
    if (rd_i) begin
      stat_d = promo;
      hid_d  = '0;
      pend_d = |(promo & qual_en);
      req_d  = |(promo & en_i);
    end else if (pend_q) begin
      hid_d = hid_q | evt_i;
    end else begin
      stat_d = stat_q | evt_i;
      pend_d = |(evt_i & qual_en);
      req_d  = |(evt_i & en_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      hid_q  <= '0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      hid_q  <= hid_d;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign stat_o = stat_q;
  assign pend_o = pend_q;
  assign req_o  = req_q;
  assign clr_o  = rd_i & pend_q;

  a_r2_visible_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !rd_i |=> $stable(stat_q));
  a_r3_hidden_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !rd_i |=> (hid_q & $past(hid_q)) == $past(hid_q));
  a_r4_hidden_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> hid_q == '0);
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !rd_i && (evt_i & qual_en) == '0 |=> !pend_q && !req_q);
  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !rd_i |=> req_q);
  a_r10_fatal_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !rd_i && (evt_i & FATAL) != '0 |=> pend_q);
  a_r1_req_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> pend_q);
endmodule

// File: rtl/intr_stack_ctrl.sv
`timescale 1ns/1ps
module intr_stack_ctrl
  import intr_stack_pkg::*;
#(
  parameter int unsigned  W         = DEF_W,
  parameter logic [W-1:0] BUS_FATAL = 8'h81,
  parameter logic [W-1:0] DMA_FATAL = 8'h41,
  parameter int unsigned  GAP_CYC   = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_evt_i,
  input  logic [W-1:0] dma_evt_i,
  input  logic         bus_en_wr_i,
  input  logic         dma_en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  input  logic         bus_rd_i,
  input  logic         dma_rd_i,
  output logic [W-1:0] bus_stat_o,
  output logic [W-1:0] dma_stat_o,
  output logic         bus_pend_o,
  output logic         dma_pend_o,
  output logic         irq_no
);
  logic [W-1:0] evt   [NUM_GRP];
  logic [W-1:0] en    [NUM_GRP];
  logic [W-1:0] stat  [NUM_GRP];
  logic         en_wr [NUM_GRP];
  logic         rd    [NUM_GRP];
  logic [NUM_GRP-1:0] pend, req, clr;
  logic         busy;

  assign evt[GRP_BUS]   = bus_evt_i;
  assign evt[GRP_DMA]   = dma_evt_i;
  assign en_wr[GRP_BUS] = bus_en_wr_i;
  assign en_wr[GRP_DMA] = dma_en_wr_i;
  assign rd[GRP_BUS]    = bus_rd_i;
  assign rd[GRP_DMA]    = dma_rd_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
    localparam logic [W-1:0] FAT = (g == GRP_BUS) ? BUS_FATAL : DMA_FATAL;

    intr_en_reg #(.W(W)) u_en (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (en_wr[g]),
      .wdata_i (en_wdata_i),
      .en_o    (en[g])
    );

    intr_grp #(.W(W), .FATAL(FAT)) u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[g]),
      .en_i   (en[g]),
      .rd_i   (rd[g]),
      .stat_o (stat[g]),
      .pend_o (pend[g]),
      .req_o  (req[g]),
      .clr_o  (clr[g])
    );
  end

  irq_gap_tmr #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (|clr),
    .busy_o (busy)
  );

  assign bus_stat_o = stat[GRP_BUS];
  assign dma_stat_o = stat[GRP_DMA];
  assign bus_pend_o = pend[GRP_BUS];
  assign dma_pend_o = pend[GRP_DMA];
  assign irq_no     = ~((|req) & ~busy);

  a_r5_pin_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr) |=> irq_no);
  a_r8_pin_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no && !bus_rd_i && !dma_rd_i |=> !irq_no);
endmodule

// File: tb/intr_stack_ctrl_tb_top.sv
`timescale 1ns/1ps
module intr_stack_ctrl_tb_top;
  localparam int unsigned W   = 8;
  localparam logic [7:0]  BUS_FAT = 8'h81;
  localparam logic [7:0]  DMA_FAT = 8'h41;
  localparam int unsigned GAP = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] bus_evt = '0, dma_evt = '0, wdata = '0;
  logic bus_en_wr = 0, dma_en_wr = 0, bus_rd = 0, dma_rd = 0;
  logic [7:0] bus_stat, dma_stat;
  logic bus_pend, dma_pend, irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  intr_stack_ctrl #(.W(W), .BUS_FATAL(BUS_FAT), .DMA_FATAL(DMA_FAT), .GAP_CYC(GAP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_evt_i(bus_evt), .dma_evt_i(dma_evt),
    .bus_en_wr_i(bus_en_wr), .dma_en_wr_i(dma_en_wr), .en_wdata_i(wdata),
    .bus_rd_i(bus_rd), .dma_rd_i(dma_rd),
    .bus_stat_o(bus_stat), .dma_stat_o(dma_stat),
    .bus_pend_o(bus_pend), .dma_pend_o(dma_pend), .irq_no(irq_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic pulse(logic [7:0] b, logic [7:0] d);
    bus_evt = b; dma_evt = d;
    tick();
    bus_evt = '0; dma_evt = '0;
  endtask

  task automatic set_en(logic [7:0] b, logic [7:0] d);
    wdata = b; bus_en_wr = 1;
    tick();
    bus_en_wr = 0; wdata = d; dma_en_wr = 1;
    tick();
    dma_en_wr = 0;
  endtask

  task automatic rd(logic b, logic d);
    bus_rd = b; dma_rd = d;
    tick();
    bus_rd = 0; dma_rd = 0;
  endtask

  task automatic quiet();
    rd(1, 1);
    repeat (GAP) tick();
  endtask

  function automatic logic [7:0] gstat(int g);
    return (g == 0) ? bus_stat : dma_stat;
  endfunction

  function automatic logic gpend(int g);
    return (g == 0) ? bus_pend : dma_pend;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R11 reset state
    chk("R11 bus_stat", bus_stat, 0);
    chk("R11 dma_stat", dma_stat, 0);
    chk("R11 pend", {bus_pend, dma_pend}, 0);
    chk("R11 irq_no", irq_n, 1);
    rst_ni = 1;
    tick();

    // R1 R6 R10 sweep: every group, bit and enable setting
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 2; e++) begin
        set_en(e ? 8'hFF : 8'h00, e ? 8'hFF : 8'h00);
        for (int i = 0; i < 8; i++) begin
          logic fat;
          logic [7:0] v;
          v = 8'(1 << i);
          fat = (g == 0) ? BUS_FAT[i] : DMA_FAT[i];
          if (g == 0) pulse(v, 0); else pulse(0, v);
          chk("R1 sweep stat", gstat(g), v);
          chk(fat ? "R10 sweep pend" : (e ? "R1 sweep pend" : "R6 sweep pend"),
              gpend(g), 32'(fat | (e != 0)));
          chk(e ? "R1 sweep irq" : "R6 R10 sweep irq", irq_n, 32'(e == 0));
          quiet();
          chk("R4 sweep cleared", gstat(g), 0);
          chk("R4 sweep pend cleared", gpend(g), 0);
        end
      end
    end

    // R2 R3 R4 R5 stacking, merge, promotion and gap
    set_en(8'hFF, 8'hFF);
    pulse(8'h02, 0);
    chk("R1 first", bus_stat, 8'h02);
    chk("R1 irq", irq_n, 0);
    pulse(8'h04, 0);
    chk("R2 visible frozen", bus_stat, 8'h02);
    pulse(8'h08, 0);
    chk("R2 visible frozen again", bus_stat, 8'h02);
    chk("R2 irq held", irq_n, 0);
    rd(1, 0);
    chk("R3 R4 promoted merge", bus_stat, 8'h0C);
    chk("R4 pend after promote", bus_pend, 1);
    chk("R5 gap start", irq_n, 1);
    repeat (GAP - 1) tick();
    chk("R5 gap last cycle", irq_n, 1);
    tick();
    chk("R5 reassert", irq_n, 0);
    rd(1, 0);
    chk("R4 empty promote", bus_stat, 0);
    chk("R4 pend clear", bus_pend, 0);
    repeat (GAP + 1) tick();
    chk("R5 stays idle", irq_n, 1);

    // R6 R7 masked nonfatal then later event
    set_en(8'h00, 8'h00);
    pulse(8'h04, 0);
    chk("R6 posted", bus_stat, 8'h04);
    chk("R6 no pend", bus_pend, 0);
    chk("R6 no irq", irq_n, 1);
    set_en(8'hFF, 8'h00);
    pulse(8'h10, 0);
    chk("R7 direct plus old", bus_stat, 8'h14);
    chk("R7 pend", bus_pend, 1);
    chk("R7 irq", irq_n, 0);
    quiet();

    // R8 enable change while pin active
    set_en(8'hFF, 8'hFF);
    pulse(8'h02, 0);
    chk("R8 irq before", irq_n, 0);
    set_en(8'h00, 8'h00);
    chk("R8 irq after disable", irq_n, 0);
    chk("R8 pend after disable", bus_pend, 1);
    quiet();

    // R9 simultaneous events in both groups
    set_en(8'hFF, 8'hFF);
    pulse(8'h06, 8'h30);
    chk("R9 bus both bits", bus_stat, 8'h06);
    chk("R9 dma both bits", dma_stat, 8'h30);
    chk("R9 both pend", {bus_pend, dma_pend}, 2'b11);
    quiet();

    // R10 disabled fatal, then stacked nonfatal promoted without pend
    set_en(8'h00, 8'h00);
    pulse(8'h80, 0);
    chk("R10 fatal posted", bus_stat, 8'h80);
    chk("R10 fatal pend", bus_pend, 1);
    chk("R10 no irq", irq_n, 1);
    pulse(8'h02, 0);
    chk("R2 stacked behind fatal", bus_stat, 8'h80);
    rd(1, 0);
    chk("R4 promoted masked", bus_stat, 8'h02);
    chk("R4 masked no pend", bus_pend, 0);
    quiet();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule